// File: doc/BRIEF.md
# Dual-Tone Keypad Signal Synthesizer

The block turns a stored four-bit keypad digit into a digital stream of dual-tone samples. Software first writes a tone register with the digit and an enable-for-keypad-signalling bit. Tone output then begins at the next low-to-high change of the transmit enable input. One phase accumulator runs at the row frequency and one at the column frequency. Both index a single 64-point sine table, and the two sine values are added together and clipped to the output width. Each new sample is announced by a one-cycle strobe.

The digit is captured at the start edge, so the tone register can be reloaded for the next digit while the current one is still sounding. Dropping transmit enable stops the strobes at once, forces the output to zero and returns both accumulators to phase zero. A parameter chooses between two table arrangements: one table read twice per sample period, or two table reads done in parallel. Both produce the same samples.

Top module: `dtmf_synth`

## Requirements
- R1: While rst_n is low and in the first cycle after it, smp_stb is 0 and smp_out is 0.
- R2: Digit bits [3:2] pick the row tone, index 0..3 giving 697, 770, 852 and 941 Hz. Bits [1:0] pick the column tone, index 0..3 giving 1209, 1336, 1477 and 1633 Hz. All 16 digits are valid.
- R3: Each tone's phase step is round(f * 2^PHASE_W / SAMPLE_HZ). Sample n after a start uses phase n*step mod 2^PHASE_W for each tone. The top six phase bits k index a sine of amplitude 127, round(127*sin(2*pi*k/64)), and smp_out is the sum of the row and column values.
- R4: Tone output starts only when tx_en is sampled 1 after having been sampled 0, and only if the tone register's mode bit is 1 at that edge.
- R5: If the mode bit is 0 at the rising edge of tx_en, no strobe occurs while tx_en stays high, even if the mode bit is set later.
- R6: The digit is captured at the start edge. Tone register writes made during output do not change the samples.
- R7: When tx_en is sampled 0, smp_stb and smp_out are 0 from the next cycle. The next start begins again from phase zero.
- R8: smp_stb is a one-cycle pulse. The first pulse follows the start edge by CLK_DIV cycles, and later pulses are CLK_DIV cycles apart.
- R9: If OUT_W is less than 9, the sum is clipped to the signed OUT_W range. Otherwise the sum is passed through with sign extension.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_we | input | 1 | Write strobe for the tone register |
| tone_code | input | 4 | Digit written to the tone register |
| tone_mode | input | 1 | Keypad-signalling select written to the tone register |
| tx_en | input | 1 | Transmit enable; a rising edge starts output |
| smp_stb | output | 1 | One-cycle pulse marking a new sample |
| smp_out | output | OUT_W | Signed dual-tone sample |

## Verification
The assertions assume that rst_n is held low for at least one cycle at power-up and that tx_en is low during reset. They also assume that a tone register write never lands in the same cycle as a start edge, because the start edge would then use the older register contents. The stimulus keeps to these assumptions: every register write is made at least one cycle before tx_en rises, and every drop of tx_en lasts several sample periods. The stimulus sweeps all 16 digits on two configurations, one unclipped with a shared table and one clipped to 8 bits with parallel table reads. Each sample is compared with an arithmetic model that tolerates one count of table rounding per tone.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

   localparam int SINE_ADDR_W = 6;
   localparam int SINE_AMP_W  = 8;

   typedef struct packed {
      logic       mode;
      logic [3:0] code;
   } tone_reg_t;

   // Row group (is_col = 0) or column group (is_col = 1) frequency in Hz
   function automatic int unsigned tone_hz(int is_col, logic [1:0] idx);
      int unsigned hz;
      if (is_col == 0) begin
         case (idx)
            2'd0:    hz = 697;
            2'd1:    hz = 770;
            2'd2:    hz = 852;
            default: hz = 941;
         endcase
      end else begin
         case (idx)
            2'd0:    hz = 1209;
            2'd1:    hz = 1336;
            2'd2:    hz = 1477;
            default: hz = 1633;
         endcase
      end
      return hz;
   endfunction

   // Rounded phase increment per sample
   function automatic logic [63:0] phase_step(int unsigned hz, int unsigned fs, int unsigned pw);
      return ((64'(hz) << pw) + 64'(fs / 2)) / 64'(fs);
   endfunction

   // First quadrant of the sine, 17 points, amplitude 127
   function automatic logic signed [SINE_AMP_W-1:0] quarter_sine(logic [4:0] k);
      logic signed [SINE_AMP_W-1:0] v;
      case (k)
         5'd0:    v = 8'sd0;
         5'd1:    v = 8'sd12;
         5'd2:    v = 8'sd25;
         5'd3:    v = 8'sd37;
         5'd4:    v = 8'sd49;
         5'd5:    v = 8'sd60;
         5'd6:    v = 8'sd71;
         5'd7:    v = 8'sd81;
         5'd8:    v = 8'sd90;
         5'd9:    v = 8'sd98;
         5'd10:   v = 8'sd106;
         5'd11:   v = 8'sd112;
         5'd12:   v = 8'sd117;
         5'd13:   v = 8'sd122;
         5'd14:   v = 8'sd125;
         5'd15:   v = 8'sd126;
         default: v = 8'sd127;
      endcase
      return v;
   endfunction

   // Full 64-point wave from quadrant symmetry
   function automatic logic signed [SINE_AMP_W-1:0] sine_lookup(logic [SINE_ADDR_W-1:0] a);
      logic [4:0]                   k;
      logic signed [SINE_AMP_W-1:0] v;
      k = a[4] ? (5'd16 - {1'b0, a[3:0]}) : {1'b0, a[3:0]};
      v = quarter_sine(k);
      return a[5] ? -v : v;
   endfunction

endpackage

// File: rtl/dtmf_ctl.sv
module dtmf_ctl #(
   parameter int CLK_DIV = 125
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tone_we,
   input  dtmf_pkg::tone_reg_t tone_wr,
   input  logic                tx_en,
   output logic                active,
   output logic                armed,
   output logic [3:0]          code_lat,
   output logic                prep,
   output logic                tick
);
   localparam int          DIV_W = $clog2(CLK_DIV);
   localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);
   localparam logic [DIV_W-1:0] PREP = DIV_W'(CLK_DIV - 2);

   dtmf_pkg::tone_reg_t tone_q;
   logic                tx_q;
   logic [DIV_W-1:0]    div_q;
   logic                start;

   assign start = tx_en & ~tx_q & tone_q.mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tone_q   <= '0;
         tx_q     <= 1'b0;
         active   <= 1'b0;
         code_lat <= '0;
         div_q    <= '0;
      end else begin
         tx_q <= tx_en;
         if (tone_we) tone_q <= tone_wr;
         if (!tx_en) begin
            active <= 1'b0;
            div_q  <= '0;
         end else if (start) begin
            active   <= 1'b1;
            code_lat <= tone_q.code;
            div_q    <= '0;
         end else if (active) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
         end
      end
   end

   assign armed = tone_q.mode;
   assign prep  = active & tx_en & (div_q == PREP);
   assign tick  = active & tx_en & (div_q == LAST);

endmodule

// File: rtl/dtmf_nco.sv
module dtmf_nco #(
   parameter int PHASE_W   = 16,
   parameter int SAMPLE_HZ = 8000,
   parameter int IS_COL    = 0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             adv,
   input  logic [1:0]                       idx,
   output logic [dtmf_pkg::SINE_ADDR_W-1:0] addr
);
   localparam logic [PHASE_W-1:0] ST0 =
      PHASE_W'(dtmf_pkg::phase_step(dtmf_pkg::tone_hz(IS_COL, 2'd0), SAMPLE_HZ, PHASE_W));
   localparam logic [PHASE_W-1:0] ST1 =
      PHASE_W'(dtmf_pkg::phase_step(dtmf_pkg::tone_hz(IS_COL, 2'd1), SAMPLE_HZ, PHASE_W));
   localparam logic [PHASE_W-1:0] ST2 =
      PHASE_W'(dtmf_pkg::phase_step(dtmf_pkg::tone_hz(IS_COL, 2'd2), SAMPLE_HZ, PHASE_W));
   localparam logic [PHASE_W-1:0] ST3 =
      PHASE_W'(dtmf_pkg::phase_step(dtmf_pkg::tone_hz(IS_COL, 2'd3), SAMPLE_HZ, PHASE_W));

   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] step;

   always_comb begin
      case (idx)
         2'd0:    step = ST0;
         2'd1:    step = ST1;
         2'd2:    step = ST2;
         default: step = ST3;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) phase_q <= '0;
      else if (adv)      phase_q <= phase_q + step;
   end

   assign addr = phase_q[PHASE_W-1 -: dtmf_pkg::SINE_ADDR_W];

endmodule

// File: rtl/dtmf_sine_path.sv
module dtmf_sine_path #(
   parameter int SHARE_ROM = 1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   prep,
   input  logic [dtmf_pkg::SINE_ADDR_W-1:0]       row_addr,
   input  logic [dtmf_pkg::SINE_ADDR_W-1:0]       col_addr,
   output logic signed [dtmf_pkg::SINE_AMP_W-1:0] row_s,
   output logic signed [dtmf_pkg::SINE_AMP_W-1:0] col_s
);
   localparam int AW = dtmf_pkg::SINE_ADDR_W;
   localparam int VW = dtmf_pkg::SINE_AMP_W;

   logic signed [VW-1:0] row_hold;

   generate
      if (SHARE_ROM != 0) begin : g_shared
         // One table: row read in the prep cycle, column read in the tick cycle
         logic [AW-1:0]        rd_addr;
         logic signed [VW-1:0] rd_val;
         assign rd_addr = prep ? row_addr : col_addr;
         assign rd_val  = dtmf_pkg::sine_lookup(rd_addr);
         always_ff @(posedge clk) begin
            if (!rst_n)    row_hold <= '0;
            else if (prep) row_hold <= rd_val;
         end
         assign col_s = rd_val;
      end else begin : g_dual
         // Two tables read side by side in the prep cycle
         logic signed [VW-1:0] col_hold;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               row_hold <= '0;
               col_hold <= '0;
            end else if (prep) begin
               row_hold <= dtmf_pkg::sine_lookup(row_addr);
               col_hold <= dtmf_pkg::sine_lookup(col_addr);
            end
         end
         assign col_s = col_hold;
      end
   endgenerate

   assign row_s = row_hold;

endmodule

// File: rtl/dtmf_mix.sv
module dtmf_mix #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    halt,
   input  logic                    load,
   input  logic signed [IN_W-1:0]  a,
   input  logic signed [IN_W-1:0]  b,
   output logic                    stb,
   output logic signed [OUT_W-1:0] y
);
   localparam int SUM_W = IN_W + 1;

   logic signed [SUM_W-1:0] sum;
   logic signed [OUT_W-1:0] y_next;

   assign sum = SUM_W'(a) + SUM_W'(b);

   generate
      if (OUT_W >= SUM_W) begin : g_wide
         assign y_next = OUT_W'(sum);
      end else begin : g_clip
         localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (OUT_W - 1)) - 1);
         localparam logic signed [SUM_W-1:0] LO = ~HI;
         always_comb begin
            if (sum > HI)      y_next = OUT_W'(HI);
            else if (sum < LO) y_next = OUT_W'(LO);
            else               y_next = OUT_W'(sum);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || halt) begin
         stb <= 1'b0;
         y   <= '0;
      end else begin
         stb <= load;
         if (load) y <= y_next;
      end
   end

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth #(
   parameter int SAMPLE_HZ = 8000,
   parameter int CLK_DIV   = 125,
   parameter int PHASE_W   = 16,
   parameter int OUT_W     = 9,
   parameter int SHARE_ROM = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tone_we,
   input  logic [3:0]              tone_code,
   input  logic                    tone_mode,
   input  logic                    tx_en,
   output logic                    smp_stb,
   output logic signed [OUT_W-1:0] smp_out
);
   localparam int AW = dtmf_pkg::SINE_ADDR_W;
   localparam int VW = dtmf_pkg::SINE_AMP_W;

   // Elaboration-time parameter checks
   if (CLK_DIV < 2)                  begin : g_bad_div   $error("CLK_DIV must be at least 2");           end
   if (PHASE_W < AW || PHASE_W > 32) begin : g_bad_phase $error("PHASE_W must lie in 6..32");            end
   if (SAMPLE_HZ <= 2 * 1633)        begin : g_bad_rate  $error("SAMPLE_HZ too low for highest tone");   end
   if (OUT_W < 2)                    begin : g_bad_out   $error("OUT_W must be at least 2");             end

   dtmf_pkg::tone_reg_t tone_wr;
   logic                act, armed, prep, tick;
   logic [3:0]          code_lat;
   logic [1:0][AW-1:0]  ph_addr;
   logic signed [VW-1:0] row_s, col_s;

   assign tone_wr = '{mode: tone_mode, code: tone_code};

   dtmf_ctl #(.CLK_DIV(CLK_DIV)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tone_we  (tone_we),
      .tone_wr  (tone_wr),
      .tx_en    (tx_en),
      .active   (act),
      .armed    (armed),
      .code_lat (code_lat),
      .prep     (prep),
      .tick     (tick)
   );

   // Group 0 = row (digit bits 3:2), group 1 = column (digit bits 1:0)
   for (genvar g = 0; g < 2; g++) begin : g_tone
      dtmf_nco #(.PHASE_W(PHASE_W), .SAMPLE_HZ(SAMPLE_HZ), .IS_COL(g)) u_nco (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (~act),
         .adv   (tick),
         .idx   (code_lat[2*(1-g) +: 2]),
         .addr  (ph_addr[g])
      );
   end

   dtmf_sine_path #(.SHARE_ROM(SHARE_ROM)) u_sine (
      .clk      (clk),
      .rst_n    (rst_n),
      .prep     (prep),
      .row_addr (ph_addr[0]),
      .col_addr (ph_addr[1]),
      .row_s    (row_s),
      .col_s    (col_s)
   );

   dtmf_mix #(.IN_W(VW), .OUT_W(OUT_W)) u_mix (
      .clk   (clk),
      .rst_n (rst_n),
      .halt  (~tx_en),
      .load  (tick),
      .a     (row_s),
      .b     (col_s),
      .stb   (smp_stb),
      .y     (smp_out)
   );

endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
   parameter int OUT_W = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tx_en,
   input logic                    act,
   input logic                    armed,
   input logic [3:0]              code_lat,
   input logic                    smp_stb,
   input logic signed [OUT_W-1:0] smp_out
);
   // R4
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> ($past(armed) && $past(tx_en)));

   // R6
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && $past(act)) |-> $stable(code_lat));

   // R7
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!smp_stb && smp_out == '0));

   // R8
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !smp_stb);

   // R8
   stb_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> $past(tx_en));

   // R9
   out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> (int'(smp_out) <= 254 && int'(smp_out) >= -254));

endmodule

bind dtmf_synth dtmf_synth_chk #(.OUT_W(OUT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_en    (tx_en),
   .act      (act),
   .armed    (armed),
   .code_lat (code_lat),
   .smp_stb  (smp_stb),
   .smp_out  (smp_out)
);

// File: tb/dtmf_synth_bench.sv
module dtmf_synth_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int FS         = 8000;
   localparam int PW         = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tone_we = 1'b0;
   logic [3:0] tone_code = '0;
   logic tone_mode = 1'b0;
   logic tx_en = 1'b0;
   logic stb9, stb8;
   logic signed [8:0] y9;
   logic signed [7:0] y8;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dtmf_synth #(.SAMPLE_HZ(FS), .CLK_DIV(DIV), .PHASE_W(PW), .OUT_W(9), .SHARE_ROM(1)) u_dtmf_synth (
      .clk(clk), .rst_n(rst_n), .tone_we(tone_we), .tone_code(tone_code),
      .tone_mode(tone_mode), .tx_en(tx_en), .smp_stb(stb9), .smp_out(y9));

   dtmf_synth #(.SAMPLE_HZ(FS), .CLK_DIV(DIV), .PHASE_W(PW), .OUT_W(8), .SHARE_ROM(0)) u_dtmf_synth_sat (
      .clk(clk), .rst_n(rst_n), .tone_we(tone_we), .tone_code(tone_code),
      .tone_mode(tone_mode), .tx_en(tx_en), .smp_stb(stb8), .smp_out(y8));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int freq(input int is_col, input int idx);
      int rows[4] = '{697, 770, 852, 941};
      int cols[4] = '{1209, 1336, 1477, 1633};
      return is_col ? cols[idx] : rows[idx];
   endfunction

   function automatic longint step_of(input int f);
      return ((longint'(f) << PW) + FS / 2) / FS;
   endfunction

   function automatic int sine_of(input longint ph);
      int   k;
      real  v;
      k = int'((ph % (64'd1 << PW)) >> (PW - 6));
      v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 64.0);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

   function automatic int expect_sum(input int code, input int n);
      longint rs, cs;
      rs = step_of(freq(0, code >> 2));
      cs = step_of(freq(1, code & 3));
      return sine_of(rs * n) + sine_of(cs * n);
   endfunction

   function automatic int clip8(input int v);
      return (v > 127) ? 127 : ((v < -128) ? -128 : v);
   endfunction

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   task automatic write_tone(input int code, input bit mode);
      @(negedge clk);
      tone_code = 4'(code);
      tone_mode = mode;
      tone_we   = 1'b1;
      @(negedge clk);
      tone_we   = 1'b0;
      @(negedge clk);
   endtask

   // Advances clock by clock until a strobe is seen at a falling edge
   task automatic wait_stb(output int n);
      n = 0;
      do begin
         @(posedge clk);
         @(negedge clk);
         n++;
      end while (!stb9 && n < 60);
   endtask

   task automatic check_sample(input int code, input int n);
      int e;
      e = expect_sum(code, n);
      // R2 R3: unclipped sum, shared-table variant
      check(absd(int'(y9), e) <= 2, "R2/R3 sample", int'(y9), e);
      // R9: clipped 8-bit output, parallel-table variant
      check(stb8 && absd(int'(y8), clip8(e)) <= 2, "R9 clipped sample", int'(y8), clip8(e));
   endtask

   task automatic quiet_window(input int ncyc, input string req);
      int seen = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (stb9 || stb8) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   task automatic run_tone(input int code, input int nsamp);
      int n;
      write_tone(code, 1'b1);
      tx_en = 1'b1;
      wait_stb(n);
      // R8: first strobe CLK_DIV cycles after the start edge
      check(n == DIV + 1, "R8 first latency", n, DIV + 1);
      check_sample(code, 0);
      for (int s = 1; s < nsamp; s++) begin
         if (s == 6) begin
            // R6: a new tone write during output must not alter the samples
            tone_code = 4'(code ^ 15);
            tone_mode = 1'b0;
            tone_we   = 1'b1;
            @(negedge clk);
            tone_we   = 1'b0;
            wait_stb(n);
            n++;
         end else begin
            wait_stb(n);
         end
         check(n == DIV, "R8 cadence", n, DIV);
         check_sample(code, s);
      end
      @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      // R7: stopped output is silent and zero
      check(!stb9 && y9 == 0 && y8 == 0, "R7 stop", int'(y9), 0);
      quiet_window(3 * DIV, "R7 no strobe after stop");
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!stb9 && !stb8 && y9 == 0 && y8 == 0, "R1 in reset", int'(y9), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!stb9 && !stb8 && y9 == 0 && y8 == 0, "R1 after reset", int'(y9), 0);

      // R2 R3 R6 R7 R8 R9: sweep all digits
      for (int c = 0; c < 16; c++) run_tone(c, 24);

      // R5: edge with mode clear does not start, later mode set does not either
      write_tone(5, 1'b0);
      tx_en = 1'b1;
      quiet_window(10 * DIV, "R5 mode clear");
      write_tone(5, 1'b1);
      quiet_window(10 * DIV, "R5 no edge");
      tx_en = 1'b0;
      repeat (3) @(negedge clk);

      // R4 R7: fresh edge with mode set starts from phase zero
      tx_en = 1'b1;
      wait_stb(n);
      check(n == DIV + 1, "R4 start latency", n, DIV + 1);
      check_sample(5, 0);
      for (int s = 1; s < 5; s++) begin
         wait_stb(n);
         check_sample(5, s);
      end
      tx_en = 1'b0;
      repeat (3) @(negedge clk);
      tx_en = 1'b1;
      wait_stb(n);
      // R7: restart begins again at phase zero
      check(n == DIV + 1 && y9 == 0, "R7 restart phase", int'(y9), 0);
      wait_stb(n);
      check_sample(5, 1);
      tx_en = 1'b0;
      repeat (4) @(negedge clk);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule